// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a two-part virtual address, a 16-bit segment selector plus a 32-bit byte offset, into a 32-bit linear address. The selector names one descriptor in one of two small descriptor memories: a global table shared by everything and a local table private to the current context. Each descriptor carries a base, a byte-granular limit, a present flag, a privilege level and separate read, write and execute rights. A request also carries the access type and the current privilege level of the requester. The block either adds the descriptor base to the offset or refuses the access with a protection fault and a code naming the first rule that was broken.

Descriptors are loaded by a host through a one-cycle write port that selects a table and an entry. Requests take one clock. A two-state machine tracks whether a result is on the outputs. In `ST_IDLE` no result is shown. On a request, the `GO_RESP` transition enters `ST_RESP`. In `ST_RESP`, another request takes `STAY_RESP`, and no request takes `BACK_IDLE` to `ST_IDLE`. The result registers are loaded only on a request and are cleared otherwise.

Top module: `seg_xlate_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. When `rsp_valid` is low, `rsp_fault`, `rsp_cause` and `rsp_lin` are all zero.
- R2: The selector is decoded as follows. Bits 15:3 are the entry index. Bit 2 picks the table (0 = global, 1 = local). Bits 1:0 are the requested privilege. A local entry with index 0 is an ordinary entry.
- R3: A selector with bit 2 = 0 and index 0 is null. Every access through it faults with cause 1.
- R4: An index of 2**IDX_W or more, in either table, faults with cause 2.
- R5: A descriptor whose present flag is clear faults with cause 3.
- R6: Let the effective privilege be the larger of `req_cpl` and the selector's requested privilege. If it is numerically greater than the descriptor privilege level, the access faults with cause 4.
- R7: Access encodings are 0 = read, 1 = write, 2 = execute, and 3 = read. A read without read right faults with cause 5. A write without write right faults with cause 6. An execute without execute right faults with cause 7.
- R8: An offset strictly greater than the descriptor limit faults with cause 8. An offset equal to the limit is allowed.
- R9: An access that breaks no rule returns base + offset modulo 2**32, with `rsp_fault` = 0 and `rsp_cause` = 0. A faulting access returns `rsp_lin` = 0 and `rsp_fault` = 1.
- R10: When several rules are broken at once, the reported cause is the lowest-numbered one.
- R11: A host write replaces the addressed entry at the next clock edge. A request made in the same cycle as a write to its own entry sees the old descriptor.
- R12: After reset, the outputs are zero and every entry of both tables is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Byte offset within the segment |
| req_acc | input | 2 | Access type |
| req_cpl | input | 2 | Current privilege level |
| hw_en | input | 1 | Host descriptor write strobe |
| hw_tbl | input | 1 | Table written (0 global, 1 local) |
| hw_idx | input | IDX_W | Entry written |
| hw_base | input | 32 | Descriptor base |
| hw_limit | input | 32 | Descriptor limit |
| hw_present | input | 1 | Descriptor present flag |
| hw_dpl | input | 2 | Descriptor privilege level |
| hw_rd | input | 1 | Read right |
| hw_wr | input | 1 | Write right |
| hw_ex | input | 1 | Execute right |
| rsp_valid | output | 1 | Result on the outputs |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 4 | Fault cause code, 0 when no fault |
| rsp_lin | output | 32 | Linear address |

## Verification
A host write and a translation can land in the same cycle on the same table entry. The bench provokes this on purpose: it issues a request through an entry while rewriting that entry with a new base, and then repeats the request one cycle later. Its reference model works out the expected result from the descriptor contents before it applies the write. The first result must therefore carry the old base and the second the new one. Random traffic also mixes writes and requests in the same cycles, and each result is judged against the model on every clock.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [3:0] {
        C_NONE    = 4'd0,
        C_NULL    = 4'd1,
        C_RANGE   = 4'd2,
        C_ABSENT  = 4'd3,
        C_PRIV    = 4'd4,
        C_NOREAD  = 4'd5,
        C_NOWRITE = 4'd6,
        C_NOEXEC  = 4'd7,
        C_LIMIT   = 4'd8
    } cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_READ2 = 2'd3
    } acc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        logic        present;
        logic [1:0]  dpl;
        logic        rd;
        logic        wr;
        logic        ex;
    } desc_t;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);
    localparam int DEPTH = 1 << IDX_W;

    desc_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_desc;
        end
    end

    assign rd_desc = mem_q[rd_idx];

endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
    import seg_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [15:0] sel,
    input  logic [31:0] off,
    input  logic [1:0]  acc,
    input  logic [1:0]  cpl,
    input  desc_t       desc,
    output logic        fault,
    output cause_e      cause,
    output logic [31:0] lin
);
    localparam int          DEPTH    = 1 << IDX_W;
    localparam logic [12:0] LAST_IDX = 13'(DEPTH - 1);

    logic [12:0] idx;
    logic        is_local;
    logic [1:0]  rpl;
    logic [1:0]  eff_pl;
    logic        right_ok;
    cause_e      right_cause;

    assign idx      = sel[15:3];
    assign is_local = sel[2];
    assign rpl      = sel[1:0];
    assign eff_pl   = (cpl > rpl) ? cpl : rpl;

    always_comb begin
        unique case (acc_e'(acc))
            ACC_WRITE: begin
                right_ok    = desc.wr;
                right_cause = C_NOWRITE;
            end
            ACC_EXEC: begin
                right_ok    = desc.ex;
                right_cause = C_NOEXEC;
            end
            ACC_READ, ACC_READ2: begin
                right_ok    = desc.rd;
                right_cause = C_NOREAD;
            end
            default: begin
                right_ok    = 1'b0;
                right_cause = C_NOREAD;
            end
        endcase
    end

    always_comb begin
        if (!is_local && idx == 13'd0) begin
            cause = C_NULL;
        end else if (idx > LAST_IDX) begin
            cause = C_RANGE;
        end else if (!desc.present) begin
            cause = C_ABSENT;
        end else if (eff_pl > desc.dpl) begin
            cause = C_PRIV;
        end else if (!right_ok) begin
            cause = right_cause;
        end else if (off > desc.limit) begin
            cause = C_LIMIT;
        end else begin
            cause = C_NONE;
        end
    end

    assign fault = (cause != C_NONE);
    assign lin   = fault ? 32'd0 : (desc.base + off);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [15:0]      req_sel,
    input  logic [31:0]      req_off,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_cpl,
    input  logic             hw_en,
    input  logic             hw_tbl,
    input  logic [IDX_W-1:0] hw_idx,
    input  logic [31:0]      hw_base,
    input  logic [31:0]      hw_limit,
    input  logic             hw_present,
    input  logic [1:0]       hw_dpl,
    input  logic             hw_rd,
    input  logic             hw_wr,
    input  logic             hw_ex,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [3:0]       rsp_cause,
    output logic [31:0]      rsp_lin
);
    localparam int NUM_TBL = 2;

    desc_t            wr_desc;
    desc_t            tbl_rd [NUM_TBL];
    desc_t            sel_desc;
    logic [IDX_W-1:0] rd_idx;
    logic             chk_fault;
    cause_e           chk_cause;
    logic [31:0]      chk_lin;
    state_e           state_q, state_d;

    assign wr_desc = '{base: hw_base, limit: hw_limit, present: hw_present,
                       dpl: hw_dpl, rd: hw_rd, wr: hw_wr, ex: hw_ex};
    assign rd_idx  = req_sel[3 +: IDX_W];

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        seg_desc_table #(.IDX_W(IDX_W)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hw_en && (hw_tbl == 1'(t))),
            .wr_idx  (hw_idx),
            .wr_desc (wr_desc),
            .rd_idx  (rd_idx),
            .rd_desc (tbl_rd[t])
        );
    end

    assign sel_desc = req_sel[2] ? tbl_rd[1] : tbl_rd[0];

    seg_rule_check #(.IDX_W(IDX_W)) u_chk (
        .sel   (req_sel),
        .off   (req_off),
        .acc   (req_acc),
        .cpl   (req_cpl),
        .desc  (sel_desc),
        .fault (chk_fault),
        .cause (chk_cause),
        .lin   (chk_lin)
    );

    // Next-state logic: GO_RESP, STAY_RESP, BACK_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers, loaded only when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_fault <= 1'b0;
            rsp_cause <= 4'd0;
            rsp_lin   <= 32'd0;
        end else begin
            rsp_fault <= chk_fault;
            rsp_cause <= chk_cause;
            rsp_lin   <= chk_lin;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int IDX_W = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [15:0] req_sel,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [3:0]  rsp_cause,
    input logic [31:0] rsp_lin
);
    localparam int DEPTH = 1 << IDX_W;

    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 4'd0 && rsp_lin == 32'd0));

    a_r9_fault_zero_lin: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_lin == 32'd0 && rsp_cause != 4'd0));

    a_r9_ok_zero_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 4'd0));

    a_r3_null_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel[15:2] == 14'd0) |=> (rsp_fault && rsp_cause == 4'd1));

    a_r4_range_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_sel[15:3]) >= DEPTH && !(req_sel[15:3] == 13'd0 && !req_sel[2]))
        |=> (rsp_fault && rsp_cause == 4'd2));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.IDX_W(IDX_W)) u_xlate_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_lin   (rsp_lin)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
    localparam int IDX_W = 3;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [15:0]      req_sel = '0;
    logic [31:0]      req_off = '0;
    logic [1:0]       req_acc = '0;
    logic [1:0]       req_cpl = '0;
    logic             hw_en = 1'b0;
    logic             hw_tbl = 1'b0;
    logic [IDX_W-1:0] hw_idx = '0;
    logic [31:0]      hw_base = '0;
    logic [31:0]      hw_limit = '0;
    logic             hw_present = 1'b0;
    logic [1:0]       hw_dpl = '0;
    logic             hw_rd = 1'b0;
    logic             hw_wr = 1'b0;
    logic             hw_ex = 1'b0;
    logic             rsp_valid;
    logic             rsp_fault;
    logic [3:0]       rsp_cause;
    logic [31:0]      rsp_lin;

    int checks = 0;
    int fails  = 0;

    // reference descriptor store
    logic [31:0] m_base  [2][DEPTH];
    logic [31:0] m_limit [2][DEPTH];
    bit          m_pres  [2][DEPTH];
    int          m_dpl   [2][DEPTH];
    bit          m_rd    [2][DEPTH];
    bit          m_wr    [2][DEPTH];
    bit          m_ex    [2][DEPTH];

    always #2.5 clk = ~clk;

    seg_xlate_unit #(.IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_off(req_off), .req_acc(req_acc), .req_cpl(req_cpl),
        .hw_en(hw_en), .hw_tbl(hw_tbl), .hw_idx(hw_idx), .hw_base(hw_base),
        .hw_limit(hw_limit), .hw_present(hw_present), .hw_dpl(hw_dpl),
        .hw_rd(hw_rd), .hw_wr(hw_wr), .hw_ex(hw_ex),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_lin(rsp_lin)
    );

    function automatic string tag_of(input int c);
        case (c)
            0: return "R9";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            8: return "R8";
            default: return "R7";
        endcase
    endfunction

    // behavioural reference: rules tried in increasing code order
    task automatic predict(input logic [15:0] s, input logic [31:0] o, input int a,
                           input int cp, output int c, output logic [31:0] l);
        int idx = int'(s[15:3]);
        int t   = int'(s[2]);
        int rp  = int'(s[1:0]);
        int eff = (cp > rp) ? cp : rp;
        bit ok;
        c = 0;
        if (t == 0 && idx == 0) c = 1;
        else if (idx >= DEPTH) c = 2;
        else if (!m_pres[t][idx]) c = 3;
        else if (eff > m_dpl[t][idx]) c = 4;
        else begin
            if (a == 1) begin ok = m_wr[t][idx]; if (!ok) c = 6; end
            else if (a == 2) begin ok = m_ex[t][idx]; if (!ok) c = 7; end
            else begin ok = m_rd[t][idx]; if (!ok) c = 5; end
            if (ok && o > m_limit[t][idx]) c = 8;
        end
        l = (c == 0) ? m_base[t][idx] + o : 32'd0;
    endtask

    task automatic hwset(input int t, input int i, input logic [31:0] b, input logic [31:0] lm,
                         input bit p, input int d, input bit r, input bit w, input bit x);
        hw_en = 1'b1; hw_tbl = 1'(t); hw_idx = IDX_W'(i); hw_base = b; hw_limit = lm;
        hw_present = p; hw_dpl = 2'(d); hw_rd = r; hw_wr = w; hw_ex = x;
    endtask

    // one clock: drive, predict, apply model write, then compare at next negedge
    task automatic step(input bit v, input logic [15:0] s, input logic [31:0] o,
                        input int a, input int cp, input string tag);
        int          ec;
        logic [31:0] el;
        string       tg;
        req_valid = v; req_sel = s; req_off = o; req_acc = 2'(a); req_cpl = 2'(cp);
        predict(s, o, a, cp, ec, el);
        if (!v) begin ec = 0; el = 32'd0; end
        if (hw_en) begin
            m_base[hw_tbl][hw_idx]  = hw_base;
            m_limit[hw_tbl][hw_idx] = hw_limit;
            m_pres[hw_tbl][hw_idx]  = hw_present;
            m_dpl[hw_tbl][hw_idx]   = int'(hw_dpl);
            m_rd[hw_tbl][hw_idx]    = hw_rd;
            m_wr[hw_tbl][hw_idx]    = hw_wr;
            m_ex[hw_tbl][hw_idx]    = hw_ex;
        end
        @(negedge clk);
        hw_en = 1'b0;
        tg = (tag != "") ? tag : (v ? tag_of(ec) : "R1");
        checks++;
        if (rsp_valid !== v || rsp_fault !== (ec != 0) || rsp_cause !== 4'(ec) || rsp_lin !== el) begin
            fails++;
            $display("FAIL %s: actual v=%0b f=%0b c=%0d lin=%h expected v=%0b f=%0b c=%0d lin=%h",
                     tg, rsp_valid, rsp_fault, rsp_cause, rsp_lin, v, ec != 0, ec, el);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1: watchdog expired, actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_base[t][i] = '0; m_limit[t][i] = '0; m_pres[t][i] = 0;
                m_dpl[t][i] = 0; m_rd[t][i] = 0; m_wr[t][i] = 0; m_ex[t][i] = 0;
            end
        end
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_cause !== 4'd0 || rsp_lin !== 32'd0) begin
            fails++;
            $display("FAIL R12: actual v=%0b c=%0d lin=%h expected all zero", rsp_valid, rsp_cause, rsp_lin);
        end
        rst_n = 1'b1;

        // R12: tables empty after reset
        step(1, {13'd1, 1'b0, 2'd0}, 32'd0, 0, 0, "R12");
        step(1, {13'd1, 1'b1, 2'd0}, 32'd0, 0, 0, "R12");
        step(0, 16'd0, 32'd0, 0, 0, "R1");

        // global 1: all rights, dpl 3
        hwset(0, 1, 32'h0000_1000, 32'h0000_00FF, 1, 3, 1, 1, 1);
        step(0, 16'd0, 32'd0, 0, 0, "R11");
        step(1, {13'd1, 1'b0, 2'd3}, 32'h10, 0, 3, "R9");
        step(1, {13'd1, 1'b0, 2'd0}, 32'hFF, 1, 0, "R8");
        step(1, {13'd1, 1'b0, 2'd0}, 32'h100, 2, 0, "R8");
        // global 2: read only, dpl 0
        hwset(0, 2, 32'h0002_0000, 32'h0000_0FFF, 1, 0, 1, 0, 0);
        step(0, 16'd0, 32'd0, 0, 0, "R11");
        step(1, {13'd2, 1'b0, 2'd0}, 32'h20, 0, 3, "R6");
        step(1, {13'd2, 1'b0, 2'd3}, 32'h20, 0, 0, "R6");
        step(1, {13'd2, 1'b0, 2'd0}, 32'h20, 0, 0, "R9");
        step(1, {13'd2, 1'b0, 2'd0}, 32'h20, 1, 0, "R7");
        step(1, {13'd2, 1'b0, 2'd0}, 32'h20, 2, 0, "R7");
        step(1, {13'd2, 1'b0, 2'd3}, 32'h2000, 1, 3, "R10");
        step(1, {13'd2, 1'b0, 2'd0}, 32'h2000, 1, 0, "R10");
        // global 3: write + execute, no read
        hwset(0, 3, 32'h0003_0000, 32'h0000_0FFF, 1, 3, 0, 1, 1);
        step(0, 16'd0, 32'd0, 0, 0, "R11");
        step(1, {13'd3, 1'b0, 2'd2}, 32'h4, 0, 1, "R7");
        step(1, {13'd3, 1'b0, 2'd2}, 32'h4, 3, 1, "R7");
        step(1, {13'd3, 1'b0, 2'd2}, 32'h4, 1, 1, "R9");
        // local 0 is ordinary; base wrap
        hwset(1, 0, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1, 3, 1, 1, 1);
        step(0, 16'd0, 32'd0, 0, 0, "R11");
        step(1, {13'd0, 1'b1, 2'd0}, 32'h200, 0, 0, "R2");
        step(1, {13'd0, 1'b0, 2'd0}, 32'h200, 0, 0, "R3");
        step(1, {13'd0, 1'b0, 2'd3}, 32'h0, 2, 3, "R3");
        step(1, {13'd9, 1'b1, 2'd0}, 32'h0, 0, 0, "R4");
        step(1, {13'd8, 1'b0, 2'd0}, 32'h0, 0, 0, "R4");
        // R11: same-cycle write to the entry being read
        hwset(0, 1, 32'h0050_0000, 32'h0000_00FF, 1, 3, 1, 1, 1);
        step(1, {13'd1, 1'b0, 2'd0}, 32'h8, 0, 0, "R11");
        step(1, {13'd1, 1'b0, 2'd0}, 32'h8, 0, 0, "R11");
        step(0, 16'd0, 32'd0, 0, 0, "R1");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int          t;
            logic [15:0] s;
            if ($urandom % 10 < 3)
                hwset(int'($urandom % 2), int'($urandom % DEPTH), $urandom,
                      $urandom & 32'h1FF, ($urandom % 4) != 0, int'($urandom % 4),
                      1'($urandom), 1'($urandom), 1'($urandom));
            t = int'($urandom % 2);
            s = {13'($urandom % (DEPTH + 2)), 1'(t), 2'($urandom)};
            step(($urandom % 10) < 7, s, $urandom & 32'h1FF, int'($urandom % 4),
                 int'($urandom % 4), "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule